// File: doc/BRIEF.md
# Four-Mode Barrel Shifter

This block is the shift unit of a 32-bit integer datapath. It takes an instruction's 5-bit operation code, the data word to be shifted, a second register word, and a 5-bit count field taken from the instruction. From these it produces a 32-bit shifted word and a flag that says whether the operation code names a shift. It is purely combinational. The result appears in the same cycle as its inputs.

Four operations are supported. The first is a right shift that fills with zeros. The second is a right shift that copies the sign bit into the vacated positions. The third is a left shift that fills with zeros. The fourth is a left rotate. The shift distance comes from the instruction's count field. A count field of zero is not taken literally: it means "take the distance from the low five bits of the second register". The shifter is built from five log-weighted multiplexer levels, so its depth does not depend on the shift distance.

Top module: `barrel_shift4`

## Requirements
- R1: Operation code 26 gives the data word shifted right by n, with zeros entering at bit 31.
- R2: Operation code 27 gives the data word shifted right by n, with copies of the data word's bit 31 entering at the top.
- R3: Operation code 28 gives the data word shifted left by n, with zeros entering at bit 0.
- R4: Operation code 29 gives the data word rotated left by n: bits leaving bit 31 re-enter at bit 0.
- R5: When the count field is nonzero, n equals the count field, and the register word has no effect on the result.
- R6: When the count field is zero, n equals bits 4..0 of the register word, and bits 31..5 of that word have no effect.
- R7: When n is 0, any of the four shift operations returns the data word unchanged.
- R8: For an operation code outside 26..29, the valid flag is 0 and the result is all zeros. For codes 26..29 the valid flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opCode | input | 5 | Operation code; 26..29 select the four shift modes |
| dataIn | input | 32 | Word to be shifted |
| regAmount | input | 32 | Register word; its bits 4..0 give the distance when the count field is zero |
| countField | input | 5 | Immediate shift distance; zero selects the register source |
| shiftOut | output | 32 | Shifted word, or zero when the code is not a shift |
| shiftValid | output | 1 | High when the operation code is one of the four shift modes |

## Verification
The bench sweeps every operation code against every count value, using several data patterns. It pays particular attention to the rotate's wrap of the top bits, because a design that zero-fills there would lose the bits that leave the top. The arithmetic shift of a negative word is swept as well; a design that filled those shifts with zeros would return positive results. The register-sourced distance is driven with garbage in the upper bits, which catches a design that uses the whole register or treats a zero field literally. Register changes while the count field is nonzero must leave the output unchanged. Distance zero and the non-shift codes are checked for an unchanged word and for an all-zero, invalid result.

// File: rtl/barrel_shift4_pkg.sv
package barrel_shift4_pkg;
  localparam int OP_W   = 5;
  localparam int DATA_W = 32;
  localparam int CNT_W  = $clog2(DATA_W);

  localparam logic [OP_W-1:0] OP_SHR  = OP_W'(26);
  localparam logic [OP_W-1:0] OP_SRA  = OP_W'(27);
  localparam logic [OP_W-1:0] OP_SHL  = OP_W'(28);
  localparam logic [OP_W-1:0] OP_ROTL = OP_W'(29);

  typedef struct packed {
    logic isShift;
    logic goRight;
    logic signFill;
    logic wrapAround;
  } shift_strobe_t;
endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import barrel_shift4_pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  output shift_strobe_t   strobes
);
  always_comb begin
    strobes = '0;
    unique case (opCode)
      OP_SHR:  begin strobes.isShift = 1'b1; strobes.goRight = 1'b1; end
      OP_SRA:  begin strobes.isShift = 1'b1; strobes.goRight = 1'b1; strobes.signFill = 1'b1; end
      OP_SHL:  begin strobes.isShift = 1'b1; end
      OP_ROTL: begin strobes.isShift = 1'b1; strobes.wrapAround = 1'b1; end
      default: strobes = '0;
    endcase
  end
endmodule

// File: rtl/shift_amount_sel.sv
module shift_amount_sel #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 5
) (
  input  logic [CNT_W-1:0]  countField,
  input  logic [DATA_W-1:0] regAmount,
  output logic [CNT_W-1:0]  amount
);
  logic fieldZero;
  assign fieldZero = (countField == '0);
  assign amount    = fieldZero ? regAmount[CNT_W-1:0] : countField;
endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
  import barrel_shift4_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 5
) (
  input  logic [DATA_W-1:0] dataIn,
  input  logic [CNT_W-1:0]  amount,
  input  shift_strobe_t     strobes,
  output logic [DATA_W-1:0] dataOut
);
  logic fillBit;
  assign fillBit = strobes.signFill & dataIn[DATA_W-1];

  for (genvar k = 0; k < CNT_W; k++) begin : g_level
    localparam int STEP = 1 << k;
    logic [DATA_W-1:0] levelIn;
    logic [DATA_W-1:0] levelOut;
    logic [STEP-1:0]   lowFill;

    if (k == 0) begin : g_first
      assign levelIn = dataIn;
    end else begin : g_next
      assign levelIn = g_level[k-1].levelOut;
    end

    assign lowFill = strobes.wrapAround ? levelIn[DATA_W-1:DATA_W-STEP] : {STEP{1'b0}};

    always_comb begin
      if (!amount[k])
        levelOut = levelIn;
      else if (strobes.goRight)
        levelOut = {{STEP{fillBit}}, levelIn[DATA_W-1:STEP]};
      else
        levelOut = {levelIn[DATA_W-1-STEP:0], lowFill};
    end
  end

  assign dataOut = strobes.isShift ? g_level[CNT_W-1].levelOut : '0;
endmodule

// File: rtl/barrel_shift4.sv
module barrel_shift4
  import barrel_shift4_pkg::*;
(
  input  logic [4:0]  opCode,
  input  logic [31:0] dataIn,
  input  logic [31:0] regAmount,
  input  logic [4:0]  countField,
  output logic [31:0] shiftOut,
  output logic        shiftValid
);
  shift_strobe_t    strobes;
  logic [CNT_W-1:0] amount;

  shift_ctrl u_ctrl (
    .opCode (opCode),
    .strobes(strobes)
  );

  shift_amount_sel #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_amt (
    .countField(countField),
    .regAmount (regAmount),
    .amount    (amount)
  );

  shift_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .dataIn (dataIn),
    .amount (amount),
    .strobes(strobes),
    .dataOut(shiftOut)
  );

  assign shiftValid = strobes.isShift;
endmodule

// File: rtl/barrel_shift4_chk.sv
module barrel_shift4_chk (
  input logic [4:0]  opCode,
  input logic [31:0] dataIn,
  input logic [31:0] regAmount,
  input logic [4:0]  countField,
  input logic [31:0] shiftOut,
  input logic        shiftValid
);
  logic [4:0] effN;
  assign effN = (countField != 5'd0) ? countField : regAmount[4:0];

  always_comb begin
    p_valid_range_r8: assert (shiftValid == (opCode >= 5'd26 && opCode <= 5'd29));
    p_invalid_zero_r8: assert (shiftValid || shiftOut == 32'd0);
    p_zero_amount_r7: assert (!(shiftValid && effN == 5'd0) || shiftOut == dataIn);
    p_rot_keeps_ones_r4: assert (opCode != 5'd29 || $countones(shiftOut) == $countones(dataIn));
    p_sra_sign_r2: assert (opCode != 5'd27 || shiftOut[31] == dataIn[31]);
    p_shl_low_zero_r3: assert (!(opCode == 5'd28 && effN != 5'd0) || shiftOut[0] == 1'b0);
    p_shr_top_zero_r1: assert (!(opCode == 5'd26 && effN != 5'd0) || shiftOut[31] == 1'b0);
  end
endmodule

bind barrel_shift4 barrel_shift4_chk i_chk (
  .opCode    (opCode),
  .dataIn    (dataIn),
  .regAmount (regAmount),
  .countField(countField),
  .shiftOut  (shiftOut),
  .shiftValid(shiftValid)
);

// File: tb/test_barrel_shift4.sv
module test_barrel_shift4;
  logic        clk = 1'b0;
  logic [4:0]  opCode = '0;
  logic [31:0] dataIn = '0;
  logic [31:0] regAmount = '0;
  logic [4:0]  countField = '0;
  logic [31:0] shiftOut;
  logic        shiftValid;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  barrel_shift4 i_barrel_shift4 (
    .opCode(opCode), .dataIn(dataIn), .regAmount(regAmount),
    .countField(countField), .shiftOut(shiftOut), .shiftValid(shiftValid)
  );

  function automatic logic [31:0] refShift(input logic [4:0] op, input logic [31:0] d, input int n);
    logic [63:0] dbl;
    case (op)
      5'd26: return d >> n;
      5'd27: return $unsigned($signed(d) >>> n);
      5'd28: return d << n;
      5'd29: begin dbl = {d, d} << n; return dbl[63:32]; end
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tagFor(input logic [4:0] op);
    case (op)
      5'd26: return "R1";
      5'd27: return "R2";
      5'd28: return "R3";
      5'd29: return "R4";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input logic [32:0] got, input logic [32:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h (op=%0d data=%h reg=%h field=%0d)",
               tag, got, exp, opCode, dataIn, regAmount, countField);
    end
  endtask

  task automatic apply(input logic [4:0] op, input logic [31:0] d, input logic [31:0] r, input logic [4:0] f);
    @(negedge clk);
    opCode = op; dataIn = d; regAmount = r; countField = f;
    #2;
  endtask

  function automatic bit isShiftOp(input logic [4:0] op);
    return op >= 5'd26 && op <= 5'd29;
  endfunction

  initial begin
    logic [31:0] patterns [4];
    patterns[0] = 32'h8000_0001;
    patterns[1] = 32'hF0E1_D2C3;
    patterns[2] = 32'h1234_5678;
    patterns[3] = 32'hFFFF_FFFF;

    // R8: idle state with all inputs zero
    apply(5'd0, 32'd0, 32'd0, 5'd0);
    check("R8 idle", {shiftValid, shiftOut}, 33'd0);

    // R1..R4, R8: every code against every immediate count, R5 field source
    for (int op = 0; op < 32; op++)
      for (int f = 1; f < 32; f++)
        for (int p = 0; p < 4; p++) begin
          apply(5'(op), patterns[p], 32'hFFFF_FFE0 | 32'(31 - f), 5'(f));
          check({tagFor(5'(op)), " R5 field"}, {shiftValid, shiftOut},
                {isShiftOp(5'(op)), refShift(5'(op), patterns[p], f)});
        end

    // R6: register-sourced distance, upper register bits are garbage
    for (int op = 26; op < 30; op++)
      for (int n = 0; n < 32; n++) begin
        apply(5'(op), 32'hC00F_F00D, 32'hA5A5_A5A0 ^ 32'(n) ^ 32'h0000_0000, 5'd0);
        check("R6 reg source", {shiftValid, shiftOut},
              {1'b1, refShift(5'(op), 32'hC00F_F00D, int'(regAmount[4:0]))});
      end

    // R5: register changes ignored while field is nonzero
    for (int op = 26; op < 30; op++)
      for (int r = 0; r < 8; r++) begin
        apply(5'(op), 32'h8765_4321, 32'(r * 32'h1357_9BDF), 5'd7);
        check("R5 reg ignored", {shiftValid, shiftOut},
              {1'b1, refShift(5'(op), 32'h8765_4321, 7)});
      end

    // R7: distance zero leaves word intact
    for (int op = 26; op < 30; op++)
      for (int p = 0; p < 4; p++) begin
        apply(5'(op), patterns[p], 32'hFFFF_FFE0, 5'd0);
        check("R7 zero distance", {shiftValid, shiftOut}, {1'b1, patterns[p]});
      end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule